// File: doc/BRIEF.md
# Byte UART Register Block with Prioritised Interrupt Identification

This block is the register side of a simple byte UART without FIFOs. A word-wide bus port reads and writes a small set of control and status registers placed one word apart. Received bytes come in one at a time over a valid/ready handshake and wait in a single holding register until software reads them. Every write to the data register sends its low byte out at once on a transmit strobe. The transmitter is treated as always ready.

A level interrupt output is driven from a fixed-priority choice among four sources: receive errors, received data, transmitter empty and modem status change. Software reads an identification register to learn which source is being served. The interrupt and the identification code are decoded every cycle from the current register contents. Baud rate generation, bit-level serialisation and modem pins live elsewhere. The block only stores the divisor value and samples a modem status byte.

Top module: `uart_csr_core`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero except line status, which reads 0x60 (bit5 holding-empty and bit6 transmitter-empty set). The identification register reads 0x01, `irq_o` is low and `rx_ready_o` is high.
- R2: The identification code uses this priority, highest first. Code 0x06 when any of line status bits 1..4 is set and enable bit2 is set. Code 0x04 when line status bit0 is set and enable bit0 is set. Code 0x02 when line status bit5 is set and enable bit1 is set. Code 0x00 when modem status bits 3..0 are nonzero and enable bit3 is set. Code 0x01 otherwise.
- R3: `irq_o` is high exactly when the identification code differs from 0x01, in the same cycle as the register contents that cause it.
- R4: `rx_ready_o` is the inverse of line status bit0 (data ready). On a handshake the byte is stored, bit0 is set, and `rx_err_i` bits 0/1/2 (parity/framing/break) are OR-ed into line status bits 2/3/4.
- R5: When `rx_valid_i` is high while `rx_ready_o` is low, line status bit1 (overrun) is set and the held byte is kept.
- R6: A read of offset 0 returns the held byte and clears data ready at the same clock edge.
- R7: A write to offset 0 raises `tx_valid_o` for exactly one cycle after the write edge, with `tx_data_o` equal to write data bits 7..0. Line status bits 5 and 6 stay set.
- R8: Register map at word offsets: 0 data (read/write), 1 line status (read), 2 identification (read), 3 interrupt enable (read/write, 4 bits), 4 line control (read/write), 5 modem control (read/write), 6 modem status (read), 7 divisor (write only, 16 bits, driven on `baud_div_o`). Read data appears zero-extended one cycle after the strobe and is zero in cycles without a valid read.
- R9: A write to offset 1, 2 or 6, a read of offset 7, or any access at offset 8 or above raises `bus_err_o` for one cycle, changes no state and returns zero read data.
- R10: Line status error bits 1..4 are sticky until reset. Reads do not clear them.
- R11: The modem status register captures `modem_status_i` at every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_wr_i | input | 1 | Write strobe, one cycle; wins over a read |
| bus_addr_i | input | ADDR_W | Word offset |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Registered read data |
| bus_err_o | output | 1 | Registered access error pulse |
| rx_valid_i | input | 1 | Received byte offered |
| rx_ready_o | output | 1 | Holding register is free |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 3 | Parity, framing, break flags of the byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| modem_status_i | input | 8 | Modem status byte to sample |
| baud_div_o | output | DIV_W | Stored divisor value |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong data-ready bit shows up at once on `rx_ready_o` and `irq_o`, one cycle after the edge that corrupts it. A wrong held byte or wrong sticky error bit stays hidden until the next read of offset 0 or 1, so the bench reads these back after every receive scenario. A wrong identification choice shows up on the next read of offset 2, and often on `irq_o` in the same cycle. The bench's model tracks all of this and compares every port on every clock.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int unsigned NREG = 8;
  localparam int unsigned BYTE_W = 8;

  // line status bit positions
  localparam int unsigned LS_DR   = 0;
  localparam int unsigned LS_OE   = 1;
  localparam int unsigned LS_PE   = 2;
  localparam int unsigned LS_FE   = 3;
  localparam int unsigned LS_BI   = 4;
  localparam int unsigned LS_THRE = 5;
  localparam int unsigned LS_TEMT = 6;

  // interrupt enable bit positions
  localparam int unsigned IE_RX = 0;
  localparam int unsigned IE_TX = 1;
  localparam int unsigned IE_LS = 2;
  localparam int unsigned IE_MS = 3;

  localparam logic [BYTE_W-1:0] ID_NONE = 8'h01;
  localparam logic [BYTE_W-1:0] ID_LS   = 8'h06;
  localparam logic [BYTE_W-1:0] ID_RX   = 8'h04;
  localparam logic [BYTE_W-1:0] ID_TX   = 8'h02;
  localparam logic [BYTE_W-1:0] ID_MS   = 8'h00;

  typedef enum logic [3:0] {
    SEL_DATA, SEL_LSR, SEL_IDENT, SEL_IEN,
    SEL_LCR, SEL_MCR, SEL_MSR, SEL_DIV, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     rd_ok;
    logic     wr_ok;
  } dec_t;
endpackage

// File: rtl/uart_csr_dec.sv
module uart_csr_dec
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  always_comb begin
    dec = '{sel: SEL_NONE, rd_ok: 1'b0, wr_ok: 1'b0};
    if (int'(addr) < int'(NREG)) begin
      case (addr[2:0])
        3'd0: dec = '{sel: SEL_DATA,  rd_ok: 1'b1, wr_ok: 1'b1};
        3'd1: dec = '{sel: SEL_LSR,   rd_ok: 1'b1, wr_ok: 1'b0};
        3'd2: dec = '{sel: SEL_IDENT, rd_ok: 1'b1, wr_ok: 1'b0};
        3'd3: dec = '{sel: SEL_IEN,   rd_ok: 1'b1, wr_ok: 1'b1};
        3'd4: dec = '{sel: SEL_LCR,   rd_ok: 1'b1, wr_ok: 1'b1};
        3'd5: dec = '{sel: SEL_MCR,   rd_ok: 1'b1, wr_ok: 1'b1};
        3'd6: dec = '{sel: SEL_MSR,   rd_ok: 1'b1, wr_ok: 1'b0};
        default: dec = '{sel: SEL_DIV, rd_ok: 1'b0, wr_ok: 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/uart_csr_rxhold.sv
module uart_csr_rxhold
  import uart_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [2:0]        rx_err,
  input  logic              rd_clr,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] hold,
  output logic              dr,
  output logic [3:0]        errs
);
  logic [BYTE_W-1:0] hold_q;
  logic              dr_q;
  logic              oe_q;
  logic [2:0]        line_err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      dr_q       <= 1'b0;
      oe_q       <= 1'b0;
      line_err_q <= '0;
    end else if (rx_valid && !dr_q) begin
      hold_q     <= rx_data;
      dr_q       <= 1'b1;
      line_err_q <= line_err_q | rx_err;
    end else begin
      if (rd_clr)   dr_q <= 1'b0;
      if (rx_valid) oe_q <= 1'b1;
    end
  end

  assign rx_ready = !dr_q;
  assign hold     = hold_q;
  assign dr       = dr_q;
  assign errs     = {line_err_q, oe_q};
endmodule

// File: rtl/uart_csr_irqsel.sv
module uart_csr_irqsel
  import uart_csr_pkg::*;
(
  input  logic              ls_err,
  input  logic              dr,
  input  logic              thre,
  input  logic [3:0]        ien,
  input  logic [3:0]        ms_low,
  output logic [BYTE_W-1:0] ident,
  output logic              irq
);
  always_comb begin
    if (ls_err && ien[IE_LS])          ident = ID_LS;
    else if (dr && ien[IE_RX])         ident = ID_RX;
    else if (thre && ien[IE_TX])       ident = ID_TX;
    else if ((|ms_low) && ien[IE_MS])  ident = ID_MS;
    else                               ident = ID_NONE;
  end
  assign irq = (ident != ID_NONE);
endmodule

// File: rtl/uart_csr_core.sv
module uart_csr_core
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              bus_err_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [7:0]        rx_data_i,
  input  logic [2:0]        rx_err_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic [7:0]        modem_status_i,
  output logic [DIV_W-1:0]  baud_div_o,
  output logic              irq_o
);
  localparam int unsigned IEN_W = 4;

  dec_t              dec;
  logic              rd_acc, wr_acc, do_rd, do_wr, bad_acc;
  logic [BYTE_W-1:0] hold;
  logic              dr;
  logic [3:0]        errs;
  logic [BYTE_W-1:0] lsr;
  logic [BYTE_W-1:0] ident;
  logic [IEN_W-1:0]  ien_q;
  logic [BYTE_W-1:0] lcr_q, mcr_q, msr_q;
  logic [DIV_W-1:0]  div_q;
  logic [BUS_W-1:0]  rd_val;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i[BUS_W-1:DIV_W];

  uart_csr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr_i), .dec(dec));

  assign wr_acc  = bus_wr_i;
  assign rd_acc  = bus_rd_i && !bus_wr_i;
  assign do_wr   = wr_acc && dec.wr_ok;
  assign do_rd   = rd_acc && dec.rd_ok;
  assign bad_acc = (wr_acc && !dec.wr_ok) || (rd_acc && !dec.rd_ok);

  uart_csr_rxhold u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid_i),
    .rx_data  (rx_data_i),
    .rx_err   (rx_err_i),
    .rd_clr   (do_rd && dec.sel == SEL_DATA),
    .rx_ready (rx_ready_o),
    .hold     (hold),
    .dr       (dr),
    .errs     (errs)
  );

  // transmitter never back-pressures, so both empty flags stay high
  always_comb begin
    lsr          = '0;
    lsr[LS_DR]   = dr;
    lsr[LS_OE]   = errs[0];
    lsr[LS_PE]   = errs[1];
    lsr[LS_FE]   = errs[2];
    lsr[LS_BI]   = errs[3];
    lsr[LS_THRE] = 1'b1;
    lsr[LS_TEMT] = 1'b1;
  end

  uart_csr_irqsel u_irq (
    .ls_err (|errs),
    .dr     (dr),
    .thre   (lsr[LS_THRE]),
    .ien    (ien_q),
    .ms_low (msr_q[3:0]),
    .ident  (ident),
    .irq    (irq_o)
  );

  always_comb begin
    case (dec.sel)
      SEL_DATA:  rd_val = BUS_W'(hold);
      SEL_LSR:   rd_val = BUS_W'(lsr);
      SEL_IDENT: rd_val = BUS_W'(ident);
      SEL_IEN:   rd_val = BUS_W'(ien_q);
      SEL_LCR:   rd_val = BUS_W'(lcr_q);
      SEL_MCR:   rd_val = BUS_W'(mcr_q);
      SEL_MSR:   rd_val = BUS_W'(msr_q);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      bus_err_o   <= 1'b0;
      tx_valid_o  <= 1'b0;
      tx_data_o   <= '0;
      ien_q       <= '0;
      lcr_q       <= '0;
      mcr_q       <= '0;
      msr_q       <= '0;
      div_q       <= '0;
    end else begin
      bus_rdata_o <= do_rd ? rd_val : '0;
      bus_err_o   <= bad_acc;
      tx_valid_o  <= do_wr && dec.sel == SEL_DATA;
      msr_q       <= modem_status_i;
      if (do_wr) begin
        case (dec.sel)
          SEL_DATA: tx_data_o <= bus_wdata_i[7:0];
          SEL_IEN:  ien_q     <= bus_wdata_i[IEN_W-1:0];
          SEL_LCR:  lcr_q     <= bus_wdata_i[7:0];
          SEL_MCR:  mcr_q     <= bus_wdata_i[7:0];
          SEL_DIV:  div_q     <= bus_wdata_i[DIV_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign baud_div_o = div_q;
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BUS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [BUS_W-1:0]  bus_wdata_i,
  input logic              bus_err_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              irq_o,
  input logic [7:0]        lsr,
  input logic [3:0]        ien_q,
  input logic [7:0]        ident
);
  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lsr == 8'h60 && !irq_o && rx_ready_o));

  // R4
  rx_take_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && rx_ready_o) |=> (!rx_ready_o && lsr[0]));

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && !rx_ready_o) |=> lsr[1]);

  // R7
  tx_send_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == '0) |=> (tx_valid_o && tx_data_o == $past(bus_wdata_i[7:0])));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == ADDR_W'(2)) |=> bus_err_o);

  // R2
  ls_prio_chk: assert property (@(posedge clk) disable iff (rst)
    ((|lsr[4:1]) && ien_q[2]) |-> ident == 8'h06);

  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_q == 4'h0) |-> !irq_o);
endmodule

bind uart_csr_core uart_csr_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_err_o   (bus_err_o),
  .rx_valid_i  (rx_valid_i),
  .rx_ready_o  (rx_ready_o),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .irq_o       (irq_o),
  .lsr         (lsr),
  .ien_q       (ien_q),
  .ident       (ident)
);

// File: tb/uart_csr_core_tb.sv
module uart_csr_core_tb;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;
  localparam int DIV_W  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [BUS_W-1:0]  bus_wdata_i = '0;
  logic [BUS_W-1:0]  bus_rdata_o;
  logic              bus_err_o;
  logic              rx_valid_i = 1'b0;
  logic              rx_ready_o;
  logic [7:0]        rx_data_i = '0;
  logic [2:0]        rx_err_i = '0;
  logic              tx_valid_o;
  logic [7:0]        tx_data_o;
  logic [7:0]        modem_status_i = '0;
  logic [DIV_W-1:0]  baud_div_o;
  logic              irq_o;

  uart_csr_core #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DIV_W(DIV_W)) u_dut (.*);

  int compared = 0, mismatched = 0, cyc = 0;
  bit chk_en = 1'b0, done = 1'b0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_hold, m_dr, m_oe, m_pe, m_fe, m_bi, m_ien, m_lcr, m_mcr, m_msr, m_div;
  int m_rdata, m_err, m_txv, m_txd, a;
  bit rd, wr, rdok, wrok;

  function automatic int m_lsr();
    return 32'h60 | (m_bi << 4) | (m_fe << 3) | (m_pe << 2) | (m_oe << 1) | m_dr;
  endfunction

  function automatic int m_ident();
    if ((m_oe | m_pe | m_fe | m_bi) != 0 && m_ien[2]) return 6;
    if (m_dr != 0 && m_ien[0]) return 4;
    if (m_ien[1]) return 2;
    if ((m_msr & 15) != 0 && m_ien[3]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hold = 0; m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
      m_ien = 0; m_lcr = 0; m_mcr = 0; m_msr = 0; m_div = 0;
      m_rdata = 0; m_err = 0; m_txv = 0; m_txd = 0;
    end else begin
      a  = int'(bus_addr_i);
      wr = bus_wr_i;
      rd = bus_rd_i && !bus_wr_i;
      wrok = (a == 0 || a == 3 || a == 4 || a == 5 || a == 7);
      rdok = (a <= 6);
      m_err = ((wr && !wrok) || (rd && !rdok)) ? 1 : 0;
      m_rdata = 0;
      if (rd && rdok)
        case (a)
          0: m_rdata = m_hold;
          1: m_rdata = m_lsr();
          2: m_rdata = m_ident();
          3: m_rdata = m_ien;
          4: m_rdata = m_lcr;
          5: m_rdata = m_mcr;
          default: m_rdata = m_msr;
        endcase
      m_txv = (wr && a == 0) ? 1 : 0;
      if (wr)
        case (a)
          0: m_txd = int'(bus_wdata_i[7:0]);
          3: m_ien = int'(bus_wdata_i[3:0]);
          4: m_lcr = int'(bus_wdata_i[7:0]);
          5: m_mcr = int'(bus_wdata_i[7:0]);
          7: m_div = int'(bus_wdata_i[15:0]);
          default: ;
        endcase
      if (rx_valid_i && m_dr == 0) begin
        m_hold = int'(rx_data_i);
        m_dr = 1;
        m_pe = m_pe | int'(rx_err_i[0]);
        m_fe = m_fe | int'(rx_err_i[1]);
        m_bi = m_bi | int'(rx_err_i[2]);
      end else begin
        if (rd && a == 0) m_dr = 0;
        if (rx_valid_i) m_oe = 1;
      end
      m_msr = int'(modem_status_i);
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      check("R4", "rx_ready", 32'(rx_ready_o), 32'(m_dr == 0));
      check("R3", "irq", 32'(irq_o), 32'(m_ident() != 1));
      check("R9", "bus_err", 32'(bus_err_o), 32'(m_err));
      check("R8", "rdata", bus_rdata_o, 32'(m_rdata));
      check("R8", "baud_div", 32'(baud_div_o), 32'(m_div));
      check("R7", "tx_valid", 32'(tx_valid_o), 32'(m_txv));
      if (m_txv != 0) check("R7", "tx_data", 32'(tx_data_o), 32'(m_txd));
    end
  end

  task automatic drive(bit r, bit w, int ad, int d, bit rv, int rb, int re);
    @(posedge clk); #2;
    bus_rd_i = r; bus_wr_i = w; bus_addr_i = ADDR_W'(ad); bus_wdata_i = 32'(d);
    rx_valid_i = rv; rx_data_i = 8'(rb); rx_err_i = 3'(re);
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr_reg(int ad, int d); drive(0, 1, ad, d, 0, 0, 0); idle(); endtask
  task automatic rx_byte(int b, int e); drive(0, 0, 0, 0, 1, b, e); idle(); endtask

  task automatic rd_expect(int ad, int exp, string tag);
    drive(1, 0, ad, 0, 0, 0, 0);
    idle();
    check(tag, $sformatf("read offset %0d", ad), bus_rdata_o, 32'(exp));
  endtask

  task automatic do_reset();
    @(posedge clk); #2; rst = 1'b1;
    @(posedge clk); #2; rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      compared++; mismatched++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(posedge clk); #2; rst = 1'b0; chk_en = 1'b1;
    // R1 reset state
    rd_expect(1, 'h60, "R1");
    rd_expect(2, 'h01, "R1");
    check("R1", "irq after reset", 32'(irq_o), 0);
    check("R1", "rx_ready after reset", 32'(rx_ready_o), 1);
    rd_expect(3, 0, "R1");
    // R2 transmit-empty source
    wr_reg(3, 'h2);
    rd_expect(2, 'h02, "R2");
    check("R3", "irq with tx source", 32'(irq_o), 1);
    // R4/R6 receive path
    wr_reg(3, 'h3);
    rx_byte('hA5, 0);
    check("R4", "rx_ready after accept", 32'(rx_ready_o), 0);
    rd_expect(2, 'h04, "R2");
    rd_expect(0, 'hA5, "R6");
    rd_expect(1, 'h60, "R6");
    check("R6", "rx_ready after read", 32'(rx_ready_o), 1);
    // R5 overrun
    rx_byte('h11, 0);
    rx_byte('h22, 0);
    rd_expect(0, 'h11, "R5");
    rd_expect(1, 'h62, "R5");
    wr_reg(3, 'h7);
    rd_expect(2, 'h06, "R2");
    // read and delivery in the same cycle while data ready
    rx_byte('h33, 0);
    drive(1, 0, 0, 0, 1, 'h99, 0);
    drive(0, 0, 0, 0, 1, 'h99, 0);
    check("R6", "read with pending byte", bus_rdata_o, 'h33);
    idle();
    rd_expect(0, 'h99, "R4");
    // R9 access errors
    drive(0, 1, 1, 'hFF, 0, 0, 0); idle();
    check("R9", "write to line status", 32'(bus_err_o), 1);
    rd_expect(1, 'h62, "R9");
    drive(0, 1, 2, 'hFF, 0, 0, 0); idle();
    check("R9", "write to ident", 32'(bus_err_o), 1);
    drive(1, 0, 7, 0, 0, 0, 0); idle();
    check("R9", "read of divisor", 32'(bus_err_o), 1);
    check("R9", "divisor read data", bus_rdata_o, 0);
    drive(1, 0, 12, 0, 0, 0, 0); idle();
    check("R9", "read unmapped", 32'(bus_err_o), 1);
    drive(0, 1, 9, 'h5, 0, 0, 0); idle();
    check("R9", "write unmapped", 32'(bus_err_o), 1);
    rd_expect(3, 'h7, "R9");
    // R8 read/write registers
    wr_reg(4, 'h1B); rd_expect(4, 'h1B, "R8");
    wr_reg(5, 'h03); rd_expect(5, 'h03, "R8");
    wr_reg(3, 'hFF); rd_expect(3, 'h0F, "R8");
    wr_reg(7, 'hAB1234);
    check("R8", "divisor output", 32'(baud_div_o), 'h1234);
    // R7 transmit
    drive(0, 1, 0, 'h15A, 0, 0, 0); idle();
    check("R7", "tx strobe", 32'(tx_valid_o), 1);
    check("R7", "tx byte", 32'(tx_data_o), 'h5A);
    idle();
    check("R7", "tx strobe single cycle", 32'(tx_valid_o), 0);
    rd_expect(1, 'h62, "R7");
    // R11 modem status and lowest-priority source
    do_reset();
    wr_reg(3, 'h8);
    modem_status_i = 8'h03;
    idle(); idle();
    rd_expect(2, 'h00, "R2");
    check("R3", "irq with modem source", 32'(irq_o), 1);
    rd_expect(6, 'h03, "R11");
    modem_status_i = 8'h30;
    idle(); idle();
    rd_expect(2, 'h01, "R2");
    check("R3", "irq idle", 32'(irq_o), 0);
    rd_expect(6, 'h30, "R11");
    // R10 sticky error bits
    rx_byte('h77, 1);
    rd_expect(0, 'h77, "R10");
    rd_expect(1, 'h64, "R10");
    wr_reg(3, 'h4);
    rd_expect(2, 'h06, "R10");
    repeat (5) idle();
    rd_expect(1, 'h64, "R10");
    rx_byte('h01, 6);
    rd_expect(1, 'h7D, "R4");
    do_reset();
    rd_expect(1, 'h60, "R1");
    repeat (3) idle();
    finish_run();
  end
endmodule